// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This block is the trap-decision part of the system control coprocessor of a small 32-bit RISC core. It holds the status word, the cause word and the saved exception address. Each cycle it folds an external interrupt status word and mask word into a pending flag in the cause word. It then decides whether the core must leave its normal instruction stream.

A trap is either a synchronous exception requested by the pipeline with a 5-bit code, or an interrupt. An interrupt is allowed when the current-enable bit is set and a cause line is unmasked by the status word. When a trap is taken, the unit does four things in one clock edge:
- It pushes a three-level, two-bit-per-level mode stack in the status word.
- It rewrites the cause word, keeping only selected fields.
- It saves the trapping address, accounting for branch delay slots.
- It redirects the fetch PC and its next-PC predictor to an exception vector.

A return-from-exception pops the mode stack. A coprocessor register port lets the core write and read the three registers. Between traps the fetch PC and predictor walk forward by one word on each step.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the fetch PC is 0xBFC00000, the predictor is 0xBFC00004, and status, cause and saved address all read 0.
- R2: Cause bit 10 reads 1 one clock after the bitwise AND of interrupt status and interrupt mask is nonzero, and 0 one clock after it is zero (when no interrupt is taken).
- R3: `trap_o` is high when an exception is requested, or when status bit 0 is 1 and status[15:8] AND cause[15:8] is nonzero. For this test, cause bit 10 is the pending flag of the same cycle and cause[9:8] are the software bits.
- R4: On a trap, status[5:0] becomes {status[3:0], 2'b00}, and all other status bits are kept.
- R5: A return-from-exception without a trap sets status[3:0] to the old status[5:2] and leaves status[5:4] and all higher bits unchanged.
- R6: On a trap, the new cause is (old cause AND 0x3000FF00) with the code in bits [6:2]. The code is the requested code when an exception is requested, even if an interrupt is also allowed, and 0 for an interrupt.
- R7: On a trap, the saved address is the current PC, or the current PC minus 4 when the delay-slot flag is set; cause bit 31 is set exactly when the delay-slot flag is set.
- R8: After a trap the fetch PC is 0x80000080, or 0xBFC00180 when status bit 22 is set, and the predictor is that vector plus 4.
- R9: Without a trap, each step moves the fetch PC to the predictor and advances the predictor by 4.
- R10: A taken interrupt clears cause bit 10 at the same edge as the redirect.
- R11: Register port: index 12 is status (all bits writable), index 13 is cause (only bits [9:8] writable), index 14 is the saved address (read-only); any other index reads 0. A write in a trapping cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_stat_i | input | 32 | External interrupt status word |
| irq_mask_i | input | 32 | External interrupt mask word |
| exc_req_i | input | 1 | Synchronous exception request |
| exc_code_i | input | 5 | Exception code for the request |
| cur_pc_i | input | 32 | Address of the instruction executing now |
| in_delay_i | input | 1 | Executing instruction sits in a branch delay slot |
| step_i | input | 1 | Advance fetch PC and predictor |
| rfe_i | input | 1 | Return-from-exception (mode stack pop) |
| cp_we_i | input | 1 | Register write enable |
| cp_addr_i | input | 4 | Register index for write and read |
| cp_wdata_i | input | 32 | Register write data |
| cp_rdata_o | output | 32 | Register read data (combinational) |
| trap_o | output | 1 | A trap is taken at the coming edge |
| fetch_pc_o | output | 32 | Fetch PC |
| fetch_pred_o | output | 32 | Next-PC predictor |

## Verification
The assertions check the following on every cycle:
- The stack push on each trap and the pop on each return.
- The vector choice and the predictor offset after a redirect.
- The sequential advance between traps.
- The pending flag following the interrupt inputs.
- The clearing of that flag by a taken interrupt.
- The delay-slot flag landing in cause bit 31.

Only the bench's scenarios can show the following:
- The exact interrupt-permission truth table across enable, mask and software-bit combinations.
- The partial preserve of the cause word.
- The priority of a requested code over a concurrent interrupt.
- The write-protection rules of the register port.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int XLEN      = 32;
  localparam int CODE_W    = 5;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 6;
  localparam int IRQ_BIT   = 10;
  localparam int BEV_BIT   = 22;
  localparam int BD_BIT    = 31;
  localparam int CODE_LSB  = 2;
  localparam logic [IDX_W-1:0] IDX_STATUS = 4'd12;
  localparam logic [IDX_W-1:0] IDX_CAUSE  = 4'd13;
  localparam logic [IDX_W-1:0] IDX_EPC    = 4'd14;
  localparam logic [XLEN-1:0]  CAUSE_KEEP = 32'h3000_FF00;
  localparam logic [XLEN-1:0]  CAUSE_SWWR = 32'h0000_0300;
  localparam logic [CODE_W-1:0] CODE_IRQ  = '0;
endpackage

// File: rtl/trap_status.sv
module trap_status
  import trap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] sr_q
);
  logic [XLEN-1:0] sr_d;
  logic            sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = push | wr_en | pop;
    if (push) begin
      sr_d[MODE_W-1:0] = {sr_q[MODE_W-3:0], 2'b00};
    end else if (wr_en) begin
      sr_d = wr_data;
    end else if (pop) begin
      sr_d[MODE_W-3:0] = sr_q[MODE_W-1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/trap_cause.sv
module trap_cause
  import trap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pending,
  input  logic              take,
  input  logic              irq_take,
  input  logic [CODE_W-1:0] code,
  input  logic              bd,
  input  logic              wr_en,
  input  logic [XLEN-1:0]   wr_data,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   cause_eff
);
  logic [XLEN-1:0] cause_d;

  always_comb begin
    cause_eff          = cause_q;
    cause_eff[IRQ_BIT] = pending;
  end

  always_comb begin
    cause_d = cause_eff;
    if (take) begin
      cause_d = cause_eff & CAUSE_KEEP;
      cause_d[CODE_LSB +: CODE_W] = code;
      cause_d[BD_BIT] = bd;
      if (irq_take) cause_d[IRQ_BIT] = 1'b0;
    end else if (wr_en) begin
      cause_d = (cause_eff & ~CAUSE_SWWR) | (wr_data & CAUSE_SWWR);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end
endmodule

// File: rtl/trap_pc.sv
module trap_pc
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  input  logic            step,
  input  logic [XLEN-1:0] epc_val,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pred_q,
  output logic [XLEN-1:0] epc_q
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);
  logic [XLEN-1:0] pc_d, pred_d;
  logic            pc_en;

  always_comb begin
    pc_en  = redirect | step;
    pc_d   = pred_q;
    pred_d = pred_q + WORD;
    if (redirect) begin
      pc_d   = target;
      pred_d = target + WORD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= RESET_PC;
      pred_q <= RESET_PC + WORD;
    end else if (pc_en) begin
      pc_q   <= pc_d;
      pred_q <= pred_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        epc_q <= '0;
    else if (redirect) epc_q <= epc_val;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] VEC_NORMAL = 32'h8000_0080,
  parameter logic [XLEN-1:0] VEC_BOOT   = 32'hBFC0_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   irq_stat_i,
  input  logic [XLEN-1:0]   irq_mask_i,
  input  logic              exc_req_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [XLEN-1:0]   cur_pc_i,
  input  logic              in_delay_i,
  input  logic              step_i,
  input  logic              rfe_i,
  input  logic              cp_we_i,
  input  logic [IDX_W-1:0]  cp_addr_i,
  input  logic [XLEN-1:0]   cp_wdata_i,
  output logic [XLEN-1:0]   cp_rdata_o,
  output logic              trap_o,
  output logic [XLEN-1:0]   fetch_pc_o,
  output logic [XLEN-1:0]   fetch_pred_o
);
  logic [XLEN-1:0]   sr_q, cause_q, cause_eff, epc_q, vec, epc_val;
  logic              pending, irq_take, take, sr_we, cause_we, pop;
  logic [CODE_W-1:0] code;

  assign pending  = |(irq_stat_i & irq_mask_i);
  assign irq_take = sr_q[0] & (|(sr_q[15:8] & cause_eff[15:8]));
  assign take     = exc_req_i | irq_take;
  assign code     = exc_req_i ? exc_code_i : CODE_IRQ;
  assign vec      = sr_q[BEV_BIT] ? VEC_BOOT : VEC_NORMAL;
  assign epc_val  = in_delay_i ? (cur_pc_i - XLEN'(4)) : cur_pc_i;
  assign sr_we    = cp_we_i & ~take & (cp_addr_i == IDX_STATUS);
  assign cause_we = cp_we_i & ~take & (cp_addr_i == IDX_CAUSE);
  assign pop      = rfe_i & ~take;
  assign trap_o   = take;

  trap_status u_status (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(pop),
    .wr_en(sr_we), .wr_data(cp_wdata_i), .sr_q(sr_q)
  );

  trap_cause u_cause (
    .clk(clk), .rst_n(rst_n), .pending(pending), .take(take),
    .irq_take(irq_take & ~exc_req_i), .code(code), .bd(in_delay_i),
    .wr_en(cause_we), .wr_data(cp_wdata_i),
    .cause_q(cause_q), .cause_eff(cause_eff)
  );

  trap_pc #(.RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_n), .redirect(take), .target(vec),
    .step(step_i), .epc_val(epc_val),
    .pc_q(fetch_pc_o), .pred_q(fetch_pred_o), .epc_q(epc_q)
  );

  always_comb begin
    case (cp_addr_i)
      IDX_STATUS: cp_rdata_o = sr_q;
      IDX_CAUSE:  cp_rdata_o = cause_q;
      IDX_EPC:    cp_rdata_o = epc_q;
      default:    cp_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_pkg::*;
#(
  parameter logic [XLEN-1:0] VEC_NORMAL = 32'h8000_0080,
  parameter logic [XLEN-1:0] VEC_BOOT   = 32'hBFC0_0180
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_o,
  input logic            exc_req_i,
  input logic            rfe_i,
  input logic            step_i,
  input logic            in_delay_i,
  input logic [XLEN-1:0] irq_stat_i,
  input logic [XLEN-1:0] irq_mask_i,
  input logic [XLEN-1:0] sr_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic [XLEN-1:0] fetch_pred_o
);
  a_r4_push: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (sr_q[MODE_W-1:0] == {$past(sr_q[3:0]), 2'b00}) &&
               (sr_q[XLEN-1:MODE_W] == $past(sr_q[XLEN-1:MODE_W])));

  a_r5_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe_i && !trap_o) |=> (sr_q[3:0] == $past(sr_q[5:2])) && $stable(sr_q[5:4]));

  a_r8_vector: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (fetch_pc_o == ($past(sr_q[BEV_BIT]) ? VEC_BOOT : VEC_NORMAL)) &&
               (fetch_pred_o == fetch_pc_o + 32'd4));

  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !trap_o) |=> fetch_pc_o == $past(fetch_pred_o));

  a_r10_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !exc_req_i) |=> !cause_q[IRQ_BIT]);

  a_r2_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |=> cause_q[IRQ_BIT] == $past(|(irq_stat_i & irq_mask_i)));

  a_r7_bd: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> cause_q[BD_BIT] == $past(in_delay_i));

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_o && !exc_req_i) |-> sr_q[0]);
endmodule

bind trap_ctrl trap_ctrl_chk #(.VEC_NORMAL(VEC_NORMAL), .VEC_BOOT(VEC_BOOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .trap_o(trap_o), .exc_req_i(exc_req_i),
  .rfe_i(rfe_i), .step_i(step_i), .in_delay_i(in_delay_i),
  .irq_stat_i(irq_stat_i), .irq_mask_i(irq_mask_i), .sr_q(sr_q),
  .cause_q(cause_q), .fetch_pc_o(fetch_pc_o), .fetch_pred_o(fetch_pred_o)
);

// File: tb/tb_trap_ctrl.sv
module tb_trap_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {ie, im[7:0], sw[1:0], stat[7:0], mask[7:0], expected trap}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 8'h04, 2'b00, 8'h01, 8'h01, 1'b1},
    {1'b0, 8'h04, 2'b00, 8'h01, 8'h01, 1'b0},
    {1'b1, 8'h04, 2'b00, 8'h01, 8'h00, 1'b0},
    {1'b1, 8'h01, 2'b01, 8'h00, 8'h00, 1'b1},
    {1'b1, 8'h02, 2'b01, 8'h00, 8'h00, 1'b0},
    {1'b1, 8'h00, 2'b00, 8'h03, 8'h03, 1'b0},
    {1'b1, 8'hFF, 2'b10, 8'h00, 8'h00, 1'b1},
    {1'b1, 8'h03, 2'b00, 8'hFF, 8'hFF, 1'b0}
  };

  logic clk = 1'b0, rst_n;
  logic [31:0] irq_stat, irq_mask, cur_pc, wdata, rdata, pc, pred;
  logic exc_req, in_delay, step, rfe, we, trap;
  logic [4:0] code;
  logic [3:0] addr;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_stat_i(irq_stat), .irq_mask_i(irq_mask),
    .exc_req_i(exc_req), .exc_code_i(code), .cur_pc_i(cur_pc),
    .in_delay_i(in_delay), .step_i(step), .rfe_i(rfe), .cp_we_i(we),
    .cp_addr_i(addr), .cp_wdata_i(wdata), .cp_rdata_o(rdata), .trap_o(trap),
    .fetch_pc_o(pc), .fetch_pred_o(pred)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    irq_stat = 0; irq_mask = 0; exc_req = 0; code = 0; cur_pc = 0;
    in_delay = 0; step = 0; rfe = 0; we = 0; addr = 0; wdata = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic raise(input logic [4:0] c, input logic [31:0] p, input logic dly);
    exc_req = 1; code = c; cur_pc = p; in_delay = dly;
    @(negedge clk); exc_req = 0; in_delay = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(); rst_n = 0;
    do_reset();
    // R1 reset state
    chk("R1 pc", pc, 32'hBFC0_0000);
    chk("R1 pred", pred, 32'hBFC0_0004);
    rd(4'd12, v); chk("R1 status", v, 0);
    rd(4'd13, v); chk("R1 cause", v, 0);
    rd(4'd14, v); chk("R1 epc", v, 0);

    // R3 permission table
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wr(4'd13, {22'd0, VEC[i][18:17], 8'd0});
      wr(4'd12, {16'd0, VEC[i][26:19], 7'd0, VEC[i][27]});
      irq_stat = {24'd0, VEC[i][16:9]};
      irq_mask = {24'd0, VEC[i][8:1]};
      #1 chk($sformatf("R3 vector %0d", i), {31'd0, trap}, {31'd0, VEC[i][0]});
      @(negedge clk); idle();
    end

    // R9 stepping
    do_reset();
    step = 1; @(negedge clk); @(negedge clk); step = 0;
    chk("R9 pc", pc, 32'hBFC0_0008);
    chk("R9 pred", pred, 32'hBFC0_000C);

    // R2 pending follows inputs (interrupts disabled)
    irq_stat = 32'h10; irq_mask = 32'h30; @(negedge clk);
    rd(4'd13, v); chk("R2 pending set", v, 32'h400);
    irq_mask = 32'h20; @(negedge clk);
    rd(4'd13, v); chk("R2 pending clear", v, 32'h0);

    // R11 register port
    wr(4'd12, 32'h0040_FF3C);
    rd(4'd12, v); chk("R11 status write", v, 32'h0040_FF3C);
    wr(4'd13, 32'hFFFF_FFFF);
    rd(4'd13, v); chk("R11 cause write mask", v, 32'h300);
    wr(4'd14, 32'h1234_5678);
    rd(4'd14, v); chk("R11 epc read-only", v, 32'h0);
    rd(4'd5, v);  chk("R11 unmapped", v, 32'h0);

    // R4 R6 R7 R8 exception with boot vector
    raise(5'h0C, 32'h8000_1000, 1'b0);
    chk("R8 boot vector", pc, 32'hBFC0_0180);
    chk("R8 pred", pred, 32'hBFC0_0184);
    rd(4'd12, v); chk("R4 push", v, 32'h0040_FF30);
    rd(4'd13, v); chk("R6 cause keep", v, 32'h330);
    rd(4'd14, v); chk("R7 epc", v, 32'h8000_1000);

    // R5 pop
    rfe = 1; @(negedge clk); rfe = 0;
    rd(4'd12, v); chk("R5 pop", v, 32'h0040_FF3C);

    // R7 delay slot, normal vector
    wr(4'd12, 32'h0000_0000);
    wr(4'd13, 32'h0);
    raise(5'h08, 32'h8000_2004, 1'b1);
    rd(4'd14, v); chk("R7 epc delay", v, 32'h8000_2000);
    rd(4'd13, v); chk("R7 bd", v, 32'h8000_0020);
    chk("R8 normal vector", pc, 32'h8000_0080);
    chk("R8 normal pred", pred, 32'h8000_0084);

    // R10 interrupt taken clears pending
    do_reset();
    wr(4'd12, 32'h0000_0401);
    irq_stat = 1; irq_mask = 1; cur_pc = 32'h8000_0500;
    #1 chk("R3 irq take", {31'd0, trap}, 32'd1);
    @(negedge clk);
    rd(4'd13, v); chk("R10 cleared", v, 32'h0);
    rd(4'd14, v); chk("R10 epc", v, 32'h8000_0500);
    rd(4'd12, v); chk("R4 irq push", v, 32'h0000_0404);
    @(negedge clk);
    rd(4'd13, v); chk("R2 pending back", v, 32'h400);

    // R6 requested code wins over a concurrent interrupt
    do_reset();
    wr(4'd12, 32'h0000_0401);
    irq_stat = 1; irq_mask = 1;
    raise(5'h0A, 32'h8000_0600, 1'b0);
    rd(4'd13, v); chk("R6 priority", v, 32'h428);

    // R11 write in trapping cycle dropped
    do_reset();
    addr = 4'd12; wdata = 32'h0000_00FF; we = 1;
    raise(5'h04, 32'h8000_0700, 1'b0);
    we = 0;
    rd(4'd12, v); chk("R11 write dropped", v, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule